// File: doc/BRIEF.md
# Congestion-Aware Prefetch Throttle

This unit sits beside the local prefetcher of one mesh node. It watches every packet that reaches the node, measures how long the packet spent in flight and marks the packet's source node as congested when the trip took too long. Each packet carries the sender's cycle count from the moment it was injected. The unit subtracts that stamp from its own free-running counter and compares the result with twice the unloaded latency of the path from that node. The latency threshold for each node comes from a small register file. At reset the file holds a value computed from the mesh hop distance, and a configuration port can overwrite any entry.

Prefetch requests pass through a one-entry valid/ready stage. Each accepted request yields one issue/drop decision on the next cycle. A prefetch aimed at a marked node is dropped. Demand requests always pass. The marks are wiped as a group at a fixed interval, so a congested path is retried once the interval has passed. An optional accuracy monitor counts issued prefetches and first uses of prefetched lines. When the measured hit ratio is above a set fraction, it lets prefetches through to congested nodes as well.

Back-pressure rules: a request is taken on a clock edge where `pf_valid` and `pf_ready` are both high. `pf_ready` is low only while a decision is waiting with `dec_ready` low. While `dec_valid` is high and `dec_ready` is low, the decision fields do not change. The arrival and configuration ports are plain pulses with no back-pressure.

Top module: `prefetch_throttle`

## Requirements
- R1: After reset, `dec_valid` is 0, `pf_ready` is 1, `now_cycle` is 0 and no node is marked, so every prefetch issues.
- R2: `now_cycle` advances by one each cycle, modulo 2^TS_W. Packet latency is `(now_cycle - arr_ts) mod 2^TS_W`, taken at the clock edge where `arr_valid` is high, so stamps taken before the counter wrapped give the correct small latency.
- R3: A packet marks its source node `arr_src` only when its latency is strictly greater than twice that node's threshold entry. No other node's mark changes.
- R4: An accepted prefetch (`pf_demand`=0) gives `dec_issue`=0 when its target's mark is set (and no accuracy override applies), and `dec_issue`=1 otherwise. The decision uses the marks as they stood before the accepting edge.
- R5: A demand request (`pf_demand`=1) always gives `dec_issue`=1.
- R6: All marks are cleared every CLEAR_PERIOD (default 128) cycles, at the clock edge where `now_cycle` mod 128 equals 127.
- R7: A mark set on the same edge as the periodic clear survives that clear.
- R8: The threshold entry for node n resets to BASE_LAT + HOP_LAT × (Manhattan hops from SELF_ID to n). With default parameters this gives node 15 = 16 and node 0 = 10, where node ID = y·MESH_X + x. A `cfg_we` pulse replaces entry `cfg_node` with `cfg_lat`.
- R9: With ACC_EN=1, the block counts issued prefetches and `use_pulse` events (uses are capped at the issued count). When 16·uses > ACC_THR·issued (default ACC_THR = 12), a prefetch to a marked node is issued. When the issued count saturates, both counts are halved.
- R10: `pf_ready` is low only while `dec_valid` is high and `dec_ready` is low. During that time `dec_issue` and `dec_target` hold steady.
- R11: Each accepted request produces exactly one decision, with `dec_valid` high on the following cycle and `dec_target` equal to the request's target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_valid | input | 1 | An arriving packet's header is present |
| arr_src | input | NODE_W | Source node of the arriving packet |
| arr_ts | input | TS_W | Injection stamp carried by the packet |
| cfg_we | input | 1 | Write strobe for the threshold table |
| cfg_node | input | NODE_W | Table entry to write |
| cfg_lat | input | LAT_W | Unloaded latency to store |
| pf_valid | input | 1 | Request present |
| pf_ready | output | 1 | Request stage can accept |
| pf_target | input | NODE_W | Node the request is sent to |
| pf_demand | input | 1 | 1 = demand request, 0 = prefetch |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_issue | output | 1 | 1 = send request, 0 = drop |
| dec_target | output | NODE_W | Target of the decided request |
| use_pulse | input | 1 | First use of a prefetched line |
| now_cycle | output | TS_W | Free-running cycle counter |

## Verification
The hardest case to reach from the ports is a congested arrival that lands exactly on the clear edge. The stimulus reads `now_cycle`, waits until it shows 126 mod 128, and then drives the arrival so that its edge is the clear edge. It also marks a second node earlier in the same interval, which shows that the clear did happen. Wrapped subtraction is exercised by arrivals right after reset, whose stamps lie "before" time zero. The accuracy override is reached by first showing a drop, then feeding enough use pulses to push the ratio past the threshold.

// File: rtl/pt_pkg.sv
package pt_pkg;
  // Manhattan distance between two node IDs on a mesh MX nodes wide.
  function automatic int unsigned pt_hops(int unsigned a, int unsigned b, int unsigned mx);
    int unsigned ax, ay, bx, by, dx, dy;
    ax = a % mx; ay = a / mx;
    bx = b % mx; by = b / mx;
    dx = (ax > bx) ? ax - bx : bx - ax;
    dy = (ay > by) ? ay - by : by - ay;
    return dx + dy;
  endfunction
endpackage

// File: rtl/pt_lat_table.sv
module pt_lat_table #(
  parameter int unsigned NODES    = 16,
  parameter int unsigned NODE_W   = 4,
  parameter int unsigned LAT_W    = 8,
  parameter int unsigned MESH_X   = 4,
  parameter int unsigned SELF_ID  = 5,
  parameter int unsigned BASE_LAT = 4,
  parameter int unsigned HOP_LAT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [NODE_W-1:0] cfg_node,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic [NODE_W-1:0] rd_node,
  output logic [LAT_W-1:0]  rd_lat
);
  logic [LAT_W-1:0] entry [NODES];

  for (genvar g = 0; g < NODES; g++) begin : g_entry
    localparam int unsigned INIT = BASE_LAT + pt_pkg::pt_hops(SELF_ID, g, MESH_X) * HOP_LAT;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry[g] <= LAT_W'(INIT);
      else if (cfg_we && cfg_node == NODE_W'(g))
        entry[g] <= cfg_lat;
    end
  end

  always_comb begin
    rd_lat = '0;
    for (int i = 0; i < NODES; i++)
      if (rd_node == NODE_W'(i)) rd_lat = entry[i];
  end
endmodule

// File: rtl/pt_cong_tracker.sv
module pt_cong_tracker #(
  parameter int unsigned NODES        = 16,
  parameter int unsigned NODE_W       = 4,
  parameter int unsigned TS_W         = 16,
  parameter int unsigned LAT_W        = 8,
  parameter int unsigned CLEAR_PERIOD = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_valid,
  input  logic [NODE_W-1:0] arr_src,
  input  logic [TS_W-1:0]   arr_ts,
  input  logic [LAT_W-1:0]  thr_lat,
  output logic [TS_W-1:0]   now,
  output logic [NODES-1:0]  cong_vec,
  output logic [NODES-1:0]  set_vec,
  output logic              clr_pulse
);
  localparam int unsigned EP_W  = (CLEAR_PERIOD > 1) ? $clog2(CLEAR_PERIOD) : 1;
  localparam int unsigned CMP_W = (TS_W > LAT_W + 1) ? TS_W : LAT_W + 1;

  logic [EP_W-1:0] epoch;
  logic [TS_W-1:0] flight;
  logic [CMP_W-1:0] flight_x, limit_x;
  logic            slow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         epoch <= '0;
    else if (clr_pulse) epoch <= '0;
    else                epoch <= epoch + 1'b1;
  end
  assign clr_pulse = (epoch == EP_W'(CLEAR_PERIOD - 1));

  // modulo subtraction handles stamps taken before the counter wrapped
  assign flight   = now - arr_ts;
  assign flight_x = CMP_W'(flight);
  assign limit_x  = CMP_W'({thr_lat, 1'b0});
  assign slow     = arr_valid && (flight_x > limit_x);

  for (genvar i = 0; i < NODES; i++) begin : g_dec
    assign set_vec[i] = slow && (arr_src == NODE_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cong_vec <= '0;
    else        cong_vec <= (clr_pulse ? '0 : cong_vec) | set_vec;
  end
endmodule

// File: rtl/pt_acc_monitor.sv
module pt_acc_monitor #(
  parameter bit          ENABLE  = 1'b1,
  parameter int unsigned ACC_W   = 6,
  parameter int unsigned ACC_THR = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic iss_pulse,
  input  logic use_pulse,
  output logic acc_ok
);
  if (ENABLE) begin : g_on
    localparam int unsigned PW = ACC_W + 5;
    localparam logic [ACC_W-1:0] CMAX = '1;
    logic [ACC_W-1:0] iss_cnt, use_cnt, use_nx;
    logic [PW-1:0] lhs, rhs;

    assign use_nx = use_cnt + ACC_W'(use_pulse && (use_cnt < iss_cnt));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        iss_cnt <= '0;
        use_cnt <= '0;
      end else if (iss_pulse && iss_cnt == CMAX) begin
        iss_cnt <= (CMAX >> 1) + 1'b1;
        use_cnt <= use_nx >> 1;
      end else begin
        iss_cnt <= iss_cnt + ACC_W'(iss_pulse);
        use_cnt <= use_nx;
      end
    end

    assign lhs    = PW'(use_cnt) << 4;
    assign rhs    = PW'(iss_cnt) * PW'(ACC_THR);
    assign acc_ok = lhs > rhs;
  end else begin : g_off
    assign acc_ok = 1'b0;
  end
endmodule

// File: rtl/prefetch_throttle.sv
module prefetch_throttle #(
  parameter int unsigned NODES        = 16,
  parameter int unsigned MESH_X       = 4,
  parameter int unsigned SELF_ID      = 5,
  parameter int unsigned TS_W         = 16,
  parameter int unsigned LAT_W        = 8,
  parameter int unsigned BASE_LAT     = 4,
  parameter int unsigned HOP_LAT      = 3,
  parameter int unsigned CLEAR_PERIOD = 128,
  parameter bit          ACC_EN       = 1'b1,
  parameter int unsigned ACC_W        = 6,
  parameter int unsigned ACC_THR      = 12,
  localparam int unsigned NODE_W      = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_valid,
  input  logic [NODE_W-1:0] arr_src,
  input  logic [TS_W-1:0]   arr_ts,
  input  logic              cfg_we,
  input  logic [NODE_W-1:0] cfg_node,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic              pf_valid,
  output logic              pf_ready,
  input  logic [NODE_W-1:0] pf_target,
  input  logic              pf_demand,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_issue,
  output logic [NODE_W-1:0] dec_target,
  input  logic              use_pulse,
  output logic [TS_W-1:0]   now_cycle
);
  logic [LAT_W-1:0] thr_lat;
  logic [NODES-1:0] cong_vec, set_vec;
  logic             clr_pulse, acc_ok;
  logic             take, issue_nx, iss_pulse;

  pt_lat_table #(
    .NODES(NODES), .NODE_W(NODE_W), .LAT_W(LAT_W), .MESH_X(MESH_X),
    .SELF_ID(SELF_ID), .BASE_LAT(BASE_LAT), .HOP_LAT(HOP_LAT)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_node(cfg_node),
    .cfg_lat(cfg_lat), .rd_node(arr_src), .rd_lat(thr_lat)
  );

  pt_cong_tracker #(
    .NODES(NODES), .NODE_W(NODE_W), .TS_W(TS_W), .LAT_W(LAT_W),
    .CLEAR_PERIOD(CLEAR_PERIOD)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_src(arr_src),
    .arr_ts(arr_ts), .thr_lat(thr_lat), .now(now_cycle),
    .cong_vec(cong_vec), .set_vec(set_vec), .clr_pulse(clr_pulse)
  );

  pt_acc_monitor #(
    .ENABLE(ACC_EN), .ACC_W(ACC_W), .ACC_THR(ACC_THR)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .iss_pulse(iss_pulse),
    .use_pulse(use_pulse), .acc_ok(acc_ok)
  );

  assign pf_ready  = !dec_valid || dec_ready;
  assign take      = pf_valid && pf_ready;
  assign issue_nx  = pf_demand || !cong_vec[pf_target] || acc_ok;
  assign iss_pulse = take && !pf_demand && issue_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_issue  <= 1'b0;
      dec_target <= '0;
    end else if (take) begin
      dec_valid  <= 1'b1;
      dec_issue  <= issue_nx;
      dec_target <= pf_target;
    end else if (dec_ready) begin
      dec_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int unsigned NODES  = 16,
  parameter int unsigned NODE_W = 4,
  parameter int unsigned TS_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [NODE_W-1:0] pf_target,
  input logic              pf_demand,
  input logic              dec_valid,
  input logic              dec_ready,
  input logic              dec_issue,
  input logic [NODE_W-1:0] dec_target,
  input logic [TS_W-1:0]   now_cycle,
  input logic [NODES-1:0]  cong_vec,
  input logic [NODES-1:0]  set_vec,
  input logic              clr_pulse,
  input logic              acc_ok
);
  // R10
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |=> dec_valid && $stable(dec_issue) && $stable(dec_target));
  // R11
  dec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready |=> dec_valid && dec_target == $past(pf_target));
  // R5
  demand_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready && pf_demand |=> dec_issue);
  // R4
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready && !pf_demand && cong_vec[pf_target] && !acc_ok |=> !dec_issue);
  // R2
  now_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> now_cycle == TS_W'($past(now_cycle) + 1'b1));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse && set_vec == '0 |=> cong_vec == '0);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (cong_vec & $past(set_vec)) == $past(set_vec));
endmodule

bind prefetch_throttle pt_checker #(
  .NODES(NODES), .NODE_W(NODE_W), .TS_W(TS_W)
) u_pt_chk (
  .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_ready(pf_ready),
  .pf_target(pf_target), .pf_demand(pf_demand), .dec_valid(dec_valid),
  .dec_ready(dec_ready), .dec_issue(dec_issue), .dec_target(dec_target),
  .now_cycle(now_cycle), .cong_vec(cong_vec), .set_vec(set_vec),
  .clr_pulse(clr_pulse), .acc_ok(acc_ok)
);

// File: tb/test_prefetch_throttle.sv
`timescale 1ns/1ps
module test_prefetch_throttle;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arr_valid = 1'b0;
  logic [3:0] arr_src = '0;
  logic [15:0] arr_ts = '0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_node = '0;
  logic [7:0] cfg_lat = '0;
  logic       pf_valid = 1'b0;
  logic       pf_ready;
  logic [3:0] pf_target = '0;
  logic       pf_demand = 1'b0;
  logic       dec_valid;
  logic       dec_ready = 1'b1;
  logic       dec_issue;
  logic [3:0] dec_target;
  logic       use_pulse = 1'b0;
  logic [15:0] now_cycle;

  int ncmp = 0;
  int nfail = 0;
  bit exp_iss[$];
  logic [3:0] exp_tgt[$];
  string exp_req[$];

  always #2.5 clk = ~clk;

  prefetch_throttle i_prefetch_throttle (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_src(arr_src),
    .arr_ts(arr_ts), .cfg_we(cfg_we), .cfg_node(cfg_node), .cfg_lat(cfg_lat),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_target(pf_target),
    .pf_demand(pf_demand), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_issue(dec_issue), .dec_target(dec_target), .use_pulse(use_pulse),
    .now_cycle(now_cycle)
  );

  task automatic chk(string req, int act, int exp);
    ncmp++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pop expected decisions as the design hands them over
  always @(negedge clk) begin
    if (rst_n && dec_valid && dec_ready) begin
      if (exp_iss.size() == 0) begin
        chk("R11 unexpected decision", 1, 0);
      end else begin
        chk(exp_req.pop_front(), int'(dec_issue), int'(exp_iss.pop_front()));
        chk("R11 target", int'(dec_target), int'(exp_tgt.pop_front()));
      end
    end
  end

  task automatic send_pf(input logic [3:0] tgt, input logic dem, input bit e, input string req);
    @(negedge clk);
    pf_valid = 1'b1; pf_target = tgt; pf_demand = dem;
    while (!pf_ready) @(negedge clk);
    exp_iss.push_back(e); exp_tgt.push_back(tgt); exp_req.push_back(req);
    @(negedge clk);
    pf_valid = 1'b0; pf_demand = 1'b0;
  endtask

  task automatic send_arr(input logic [3:0] src, input int lat);
    @(negedge clk);
    arr_valid = 1'b1; arr_src = src; arr_ts = now_cycle - 16'(lat);
    @(negedge clk);
    arr_valid = 1'b0;
  endtask

  task automatic send_cfg(input logic [3:0] node, input logic [7:0] lat);
    @(negedge clk);
    cfg_we = 1'b1; cfg_node = node; cfg_lat = lat;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_uses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); use_pulse = 1'b1;
      @(negedge clk); use_pulse = 1'b0;
    end
  endtask

  task automatic wait_phase(input int m);
    do @(negedge clk); while (int'(now_cycle) % 128 != m);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int t0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 dec_valid", int'(dec_valid), 0);
    chk("R1 pf_ready", int'(pf_ready), 1);
    chk("R1 now_cycle", int'(now_cycle), 0);
    @(negedge clk);
    chk("R2 count", int'(now_cycle), 1);

    // R2 wrapped stamps: node5 thr 4 -> limit 8, node4 thr 7 -> limit 14
    send_arr(4'd5, 20);
    send_arr(4'd4, 10);
    send_pf(4'd5, 1'b0, 1'b0, "R2 wrapped latency 20 marks node5");
    send_pf(4'd4, 1'b0, 1'b1, "R2 wrapped latency 10 leaves node4");
    for (int n = 0; n < 4; n++) send_pf(4'(n), 1'b0, 1'b1, "R1 unmarked node issues");

    // R3/R4/R5 threshold boundary on node 15 (thr 16, limit 32)
    wait_phase(0);
    send_pf(4'd5, 1'b0, 1'b1, "R6 node5 cleared");
    send_arr(4'd15, 32);
    send_pf(4'd15, 1'b0, 1'b1, "R3 latency equal to limit");
    send_arr(4'd15, 33);
    send_pf(4'd15, 1'b0, 1'b0, "R4 latency over limit drops");
    send_pf(4'd14, 1'b0, 1'b1, "R3 other node untouched");
    send_pf(4'd15, 1'b1, 1'b1, "R5 demand passes");

    // R6 periodic clear
    wait_phase(0);
    send_pf(4'd15, 1'b0, 1'b1, "R6 cleared after period");

    // R7 set on the clear edge survives; earlier mark is wiped
    wait_phase(100);
    send_arr(4'd6, 100);
    wait_phase(126);
    send_arr(4'd7, 100);
    send_pf(4'd7, 1'b0, 1'b0, "R7 set wins over clear");
    send_pf(4'd6, 1'b0, 1'b1, "R6 earlier mark cleared");

    // R8 reset value node0 (thr 10) and written entry node3
    wait_phase(0);
    send_arr(4'd0, 20);
    send_pf(4'd0, 1'b0, 1'b1, "R8 reset threshold node0 at limit");
    send_arr(4'd0, 21);
    send_pf(4'd0, 1'b0, 1'b0, "R8 reset threshold node0 exceeded");
    send_cfg(4'd3, 8'd40);
    send_arr(4'd3, 80);
    send_pf(4'd3, 1'b0, 1'b1, "R8 written threshold at limit");
    send_arr(4'd3, 81);
    send_pf(4'd3, 1'b0, 1'b0, "R8 written threshold exceeded");

    // R9 accuracy override: 12 prefetches issued so far, none used
    wait_phase(0);
    send_arr(4'd9, 100);
    send_pf(4'd9, 1'b0, 1'b0, "R9 low accuracy keeps drop");
    send_uses(12);
    send_pf(4'd9, 1'b0, 1'b1, "R9 high accuracy overrides");

    // R10 back-pressure
    @(posedge clk); #1 dec_ready = 1'b0;
    send_pf(4'd10, 1'b0, 1'b1, "R10 first under stall");
    fork
      send_pf(4'd11, 1'b0, 1'b1, "R10 second after stall");
      begin
        repeat (3) @(negedge clk);
        chk("R10 pf_ready low", int'(pf_ready), 0);
        chk("R10 dec_valid held", int'(dec_valid), 1);
        chk("R10 dec_target held", int'(dec_target), 10);
        @(posedge clk); #1 dec_ready = 1'b1;
      end
    join

    // R11 per-request decision count and latency
    t0 = int'(now_cycle);
    send_pf(4'd12, 1'b0, 1'b1, "R11 single decision");
    repeat (4) @(negedge clk);
    chk("R11 all decisions delivered", exp_iss.size(), 0);
    chk("R2 time advanced", int'(now_cycle) - t0 > 0, 1);
    finish_run();
  end
endmodule